// File: doc/BRIEF.md
# Wavefront Lane Swizzle Crossbar

This block exchanges data between the lanes of a 32-lane group. A request carries one 32-bit value per lane, a 16-bit pattern word and an active-lane mask. The pattern picks one of five rewrite rules for lane ids: quad permute, bitmask permute, broadcast, swap or reverse. For every destination lane the block works out a source lane id, reads that lane's value and registers the result. The result appears one cycle after the request is accepted.

A source lane whose mask bit is clear supplies zero. A pattern word that does not encode a legal operation returns the input data unchanged, ignores the mask, and raises an error flag for one cycle. The input is a valid/ready port. The output is a valid/ready port backed by a single register, which holds its contents until the consumer takes them.

Top module: `lane_swz`

## Requirements
- R1: With pattern bit 15 clear and bits [14:12] = 0 (quad mode), destination lane d reads lane (d with bits [1:0] replaced by selector s), where s = pattern[2k+1:2k] and k = d mod 4. Bits [11:8] must be zero.
- R2: With pattern bit 15 set (bitmask mode), the source id is ((d AND A) OR O) XOR X. Here A = pattern[4:0], O = pattern[9:5] and X = pattern[14:10].
- R3: Broadcast mode has bits [14:12] = 1, log2 group size g = pattern[7:5] in 1..5 and lane index i = pattern[4:0] with i < 2^g. Every lane of each aligned group of 2^g lanes reads lane i of that group.
- R4: Swap mode has bits [14:12] = 2 and log2 group size g = pattern[2:0] in 0..4. The source id is d XOR 2^g.
- R5: Reverse mode has bits [14:12] = 3 and log2 group size g = pattern[2:0] in 1..5. The source id is d XOR (2^g - 1), which reverses lane order within each aligned group.
- R6: If the active-mask bit of the selected source lane is 0, the destination lane outputs zero.
- R7: Pattern word 0 is the default and is a legal quad pattern: every lane reads lane 0 of its quad.
- R8: A pattern is illegal if any of the following holds. The result is then the input data unchanged, with the mask ignored, and out_err is high for exactly the one cycle after acceptance.
  - bits [14:12] are 4..7 with bit 15 clear;
  - a reserved bit is set (bits [11:8] in quad or broadcast mode, bits [11:3] in swap or reverse mode);
  - broadcast has g = 0, g > 5 or i >= 2^g;
  - swap has g > 4;
  - reverse has g = 0 or g > 5.
- R9: A request is accepted on a clock edge where in_valid and in_ready are both high. out_valid and the result are visible after that edge. in_ready is high whenever the output register is empty or out_ready is high.
- R10: While out_valid is high and out_ready is low, out_data stays constant and out_valid stays high. After a transfer with no new request accepted, out_valid goes low.
- R11: While rst_n is low, out_valid, out_err and out_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_data | input | LANES*DW | Lane values, lane n in bits [n*DW +: DW] |
| in_pattern | input | 16 | Swizzle pattern word |
| in_active | input | LANES | Active-lane mask, bit n for lane n |
| out_valid | output | 1 | Result register holds data |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | LANES*DW | Swizzled lane values |
| out_err | output | 1 | One-cycle pulse for an illegal pattern |

## Verification
The checker takes for granted that reset is held low across at least one clock edge at start-up. It also assumes in_data, in_pattern and in_active carry known values whenever in_valid is high, because the identity and hold properties compare whole data buses. The bench meets these conditions by driving every input at the falling edge, from defined patterns only. It holds reset for several cycles and keeps out_ready at a known level throughout, including the stall sequence, in which a second request waits while the first result is held.

// File: rtl/lane_swz_pkg.sv
package lane_swz_pkg;

   localparam int SWZ_PATW = 16;
   localparam int SWZ_MAX_IDW = 5;

   typedef enum logic [2:0] {
      SWZ_M_QUAD  = 3'd0,
      SWZ_M_BCAST = 3'd1,
      SWZ_M_SWAP  = 3'd2,
      SWZ_M_REV   = 3'd3
   } swz_mode_e;

   // Decoded control. Every mode except quad reduces to one
   // and/or/xor rewrite of the destination id.
   typedef struct packed {
      logic                   use_quad;
      logic [7:0]             qsel;
      logic [SWZ_MAX_IDW-1:0] and_m;
      logic [SWZ_MAX_IDW-1:0] or_m;
      logic [SWZ_MAX_IDW-1:0] xor_m;
      logic                   err;
   } swz_ctl_t;

endpackage

// File: rtl/lane_swz_decode.sv
module lane_swz_decode
   import lane_swz_pkg::*;
#(
   parameter int IDW = 5
) (
   input  logic [SWZ_PATW-1:0] pattern,
   output swz_ctl_t            ctl
);

   localparam logic [2:0] KMAX = 3'(IDW);

   logic [2:0] k_grp;
   logic [2:0] k_sh;
   logic [4:0] idx;
   logic [4:0] gm_grp;
   logic [4:0] gm_sh;
   logic       bad;

   assign k_grp  = pattern[7:5];
   assign k_sh   = pattern[2:0];
   assign idx    = pattern[4:0];
   assign gm_grp = 5'((7'd1 << k_grp) - 7'd1);
   assign gm_sh  = 5'((7'd1 << k_sh) - 7'd1);

   always_comb begin
      ctl.use_quad = 1'b0;
      ctl.qsel     = pattern[7:0];
      ctl.and_m    = '1;
      ctl.or_m     = '0;
      ctl.xor_m    = '0;
      bad          = 1'b0;
      if (pattern[15]) begin
         ctl.and_m = pattern[4:0];
         ctl.or_m  = pattern[9:5];
         ctl.xor_m = pattern[14:10];
      end else begin
         case (pattern[14:12])
            SWZ_M_QUAD: begin
               ctl.use_quad = 1'b1;
               bad          = |pattern[11:8];
            end
            SWZ_M_BCAST: begin
               if ((|pattern[11:8]) || (k_grp == 3'd0) || (k_grp > KMAX) ||
                   (|(idx & ~gm_grp)))
                  bad = 1'b1;
               else begin
                  ctl.and_m = ~gm_grp;
                  ctl.or_m  = idx & gm_grp;
               end
            end
            SWZ_M_SWAP: begin
               if ((|pattern[11:3]) || (k_sh >= KMAX))
                  bad = 1'b1;
               else
                  ctl.xor_m = 5'(7'd1 << k_sh);
            end
            SWZ_M_REV: begin
               if ((|pattern[11:3]) || (k_sh == 3'd0) || (k_sh > KMAX))
                  bad = 1'b1;
               else
                  ctl.xor_m = gm_sh;
            end
            default: bad = 1'b1;
         endcase
      end
      if (bad) begin
         ctl.use_quad = 1'b0;
         ctl.and_m    = '1;
         ctl.or_m     = '0;
         ctl.xor_m    = '0;
      end
      ctl.err = bad;
   end

endmodule

// File: rtl/lane_swz_srcgen.sv
module lane_swz_srcgen
   import lane_swz_pkg::*;
#(
   parameter int LANES = 32,
   parameter int IDW   = $clog2(LANES)
) (
   input  swz_ctl_t               ctl,
   output logic [LANES*IDW-1:0]   src_ids
);

   for (genvar d = 0; d < LANES; d++) begin : g_lane
      localparam logic [IDW-1:0] DST = IDW'(d);
      localparam int QPOS = 2 * (d % 4);
      logic [IDW-1:0] mask_src;
      logic [IDW-1:0] quad_src;

      assign mask_src = ((DST & ctl.and_m[IDW-1:0]) | ctl.or_m[IDW-1:0])
                        ^ ctl.xor_m[IDW-1:0];

      if (IDW > 2) begin : g_wide
         assign quad_src = {DST[IDW-1:2], ctl.qsel[QPOS +: 2]};
      end else begin : g_narrow
         assign quad_src = ctl.qsel[QPOS +: 2];
      end

      assign src_ids[d*IDW +: IDW] = ctl.use_quad ? quad_src : mask_src;
   end

endmodule

// File: rtl/lane_swz_xbar.sv
module lane_swz_xbar #(
   parameter int LANES = 32,
   parameter int DW    = 32,
   parameter int IDW   = $clog2(LANES)
) (
   input  logic [LANES*DW-1:0]  data_in,
   input  logic [LANES-1:0]     active,
   input  logic [LANES*IDW-1:0] src_ids,
   input  logic                 bypass,
   output logic [LANES*DW-1:0]  data_out
);

   for (genvar d = 0; d < LANES; d++) begin : g_lane
      logic [IDW-1:0] src;
      logic [DW-1:0]  pick;

      assign src  = src_ids[d*IDW +: IDW];
      assign pick = active[src] ? data_in[src*DW +: DW] : '0;
      assign data_out[d*DW +: DW] = bypass ? data_in[d*DW +: DW] : pick;
   end

endmodule

// File: rtl/lane_swz.sv
module lane_swz
   import lane_swz_pkg::*;
#(
   parameter int LANES = 32,
   parameter int DW    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [LANES*DW-1:0] in_data,
   input  logic [15:0]         in_pattern,
   input  logic [LANES-1:0]    in_active,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [LANES*DW-1:0] out_data,
   output logic                out_err
);

   localparam int IDW  = $clog2(LANES);
   localparam int BUSW = LANES * DW;

   if ((LANES & (LANES - 1)) != 0) begin : g_bad_pow2
      $error("lane_swz: LANES must be a power of two");
   end
   if (LANES < 4 || IDW > SWZ_MAX_IDW) begin : g_bad_range
      $error("lane_swz: LANES must lie in 4..32");
   end
   if (DW < 1) begin : g_bad_dw
      $error("lane_swz: DW must be positive");
   end

   swz_ctl_t             ctl;
   logic [LANES*IDW-1:0] src_ids;
   logic [BUSW-1:0]      result;
   logic                 accept;
   logic                 valid_q;
   logic                 err_q;
   logic [BUSW-1:0]      data_q;

   lane_swz_decode #(.IDW(IDW)) u_decode (
      .pattern (in_pattern),
      .ctl     (ctl)
   );

   lane_swz_srcgen #(.LANES(LANES), .IDW(IDW)) u_srcgen (
      .ctl     (ctl),
      .src_ids (src_ids)
   );

   lane_swz_xbar #(.LANES(LANES), .DW(DW), .IDW(IDW)) u_xbar (
      .data_in  (in_data),
      .active   (in_active),
      .src_ids  (src_ids),
      .bypass   (ctl.err),
      .data_out (result)
   );

   assign in_ready = !valid_q || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         data_q  <= '0;
      end else begin
         err_q <= accept && ctl.err;
         if (accept) begin
            valid_q <= 1'b1;
            data_q  <= result;
         end else if (out_ready) begin
            valid_q <= 1'b0;
         end
      end
   end

   assign out_valid = valid_q;
   assign out_data  = data_q;
   assign out_err   = err_q;

endmodule

// File: rtl/lane_swz_chk.sv
module lane_swz_chk #(
   parameter int LANES = 32,
   parameter int DW    = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic [LANES*DW-1:0] in_data,
   input logic [15:0]         in_pattern,
   input logic [LANES-1:0]    in_active,
   input logic                out_valid,
   input logic                out_ready,
   input logic [LANES*DW-1:0] out_data,
   input logic                out_err
);

   assert_identity_quad_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_pattern == 16'h00E4 && (&in_active))
      |=> (out_data == $past(in_data)));

   assert_err_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_valid);

   assert_err_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> $past(in_valid && in_ready));

   assert_accept_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);

   assert_reset_clear_R11: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !out_err));

endmodule

bind lane_swz lane_swz_chk #(.LANES(LANES), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_data    (in_data),
   .in_pattern (in_pattern),
   .in_active  (in_active),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .out_err    (out_err)
);

// File: tb/lane_swz_bench.sv
`timescale 1ns/1ps
module lane_swz_bench;

   localparam int LANES = 32;
   localparam int DW    = 32;
   localparam int BUSW  = LANES * DW;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             in_valid;
   logic             in_ready;
   logic [BUSW-1:0]  in_data;
   logic [15:0]      in_pattern;
   logic [LANES-1:0] in_active;
   logic             out_valid;
   logic             out_ready;
   logic [BUSW-1:0]  out_data;
   logic             out_err;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   lane_swz u_lane_swz (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_pattern(in_pattern), .in_active(in_active),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_err(out_err)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL R9 watchdog: cycles=%0d expected < 20000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk_bus(input logic [BUSW-1:0] act, input logic [BUSW-1:0] exp,
                          input string req, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_bit(input logic act, input logic exp,
                          input string req, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   // Pattern builders following the encodings in the requirements.
   function automatic logic [15:0] p_quad(input int s0, s1, s2, s3);
      return 16'({2'(s3), 2'(s2), 2'(s1), 2'(s0)});
   endfunction
   function automatic logic [15:0] p_bm(input int a, o, x);
      return {1'b1, 5'(x), 5'(o), 5'(a)};
   endfunction
   function automatic logic [15:0] p_bc(input int g, i);
      return {1'b0, 3'd1, 4'd0, 3'(g), 5'(i)};
   endfunction
   function automatic logic [15:0] p_sw(input int g);
      return {1'b0, 3'd2, 9'd0, 3'(g)};
   endfunction
   function automatic logic [15:0] p_rv(input int g);
      return {1'b0, 3'd3, 9'd0, 3'(g)};
   endfunction

   // Source lane for destination d, or -1 for an illegal pattern.
   function automatic int src_of(input int d, input logic [15:0] p);
      int g, i;
      if (p[15]) return ((d & int'(p[4:0])) | int'(p[9:5])) ^ int'(p[14:10]);
      case (p[14:12])
         3'd0: begin
            if (p[11:8] != 0) return -1;
            return (d & ~3) | ((int'(p[7:0]) >> (2 * (d % 4))) & 3);
         end
         3'd1: begin
            g = int'(p[7:5]); i = int'(p[4:0]);
            if (p[11:8] != 0 || g < 1 || g > 5 || i >= (1 << g)) return -1;
            return (d & ~((1 << g) - 1)) | i;
         end
         3'd2: begin
            g = int'(p[2:0]);
            if (p[11:3] != 0 || g > 4) return -1;
            return d ^ (1 << g);
         end
         3'd3: begin
            g = int'(p[2:0]);
            if (p[11:3] != 0 || g < 1 || g > 5) return -1;
            return d ^ ((1 << g) - 1);
         end
         default: return -1;
      endcase
   endfunction

   function automatic logic [BUSW-1:0] mk_data(input logic [15:0] seed);
      logic [BUSW-1:0] r;
      for (int n = 0; n < LANES; n++)
         r[n*DW +: DW] = {seed, 8'(n), 8'(n * 13) ^ seed[7:0]};
      return r;
   endfunction

   function automatic logic [BUSW-1:0] model(input logic [BUSW-1:0] d,
                                             input logic [15:0] p,
                                             input logic [LANES-1:0] a);
      logic [BUSW-1:0] r;
      int s;
      for (int n = 0; n < LANES; n++) begin
         s = src_of(n, p);
         if (s < 0) r[n*DW +: DW] = d[n*DW +: DW];
         else       r[n*DW +: DW] = a[s] ? d[s*DW +: DW] : '0;
      end
      return r;
   endfunction

   task automatic run_one(input logic [15:0] pat, input logic [LANES-1:0] act,
                          input logic [15:0] seed, input string req);
      logic [BUSW-1:0] d;
      logic [BUSW-1:0] exp;
      logic            eerr;
      d    = mk_data(seed);
      exp  = model(d, pat, act);
      eerr = (src_of(0, pat) < 0);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_pattern = pat; in_active = act;
      @(negedge clk);
      in_valid = 1'b0;
      chk_bit(out_valid, 1'b1, "R9", "valid one cycle after accept");
      chk_bus(out_data, exp, req, $sformatf("data for pattern %h", pat));
      chk_bit(out_err, eerr, "R8", $sformatf("error flag for pattern %h", pat));
      @(negedge clk);
      chk_bit(out_valid, 1'b0, "R10", "valid drops after transfer");
      chk_bit(out_err, 1'b0, "R8", "error flag lasts one cycle");
   endtask

   task automatic t_reset();
      chk_bit(out_valid, 1'b0, "R11", "valid in reset");
      chk_bit(out_err, 1'b0, "R11", "error in reset");
      chk_bus(out_data, '0, "R11", "data in reset");
      chk_bit(in_ready, 1'b1, "R9", "ready when empty");
   endtask

   task automatic t_quad();
      run_one(p_quad(0, 1, 2, 3), '1, 16'h1101, "R1");
      run_one(p_quad(3, 2, 1, 0), '1, 16'h1202, "R1");
      run_one(p_quad(1, 1, 3, 0), '1, 16'h1303, "R1");
   endtask

   task automatic t_default();
      run_one(16'h0000, '1, 16'h7707, "R7");
   endtask

   task automatic t_bitmask();
      run_one(p_bm(31, 0, 16), '1, 16'h2101, "R2");
      run_one(p_bm(6, 8, 2), '1, 16'h2202, "R2");
      run_one(p_bm(0, 21, 31), '1, 16'h2303, "R2");
   endtask

   task automatic t_bcast();
      run_one(p_bc(1, 1), '1, 16'h3101, "R3");
      run_one(p_bc(3, 5), '1, 16'h3202, "R3");
      run_one(p_bc(5, 31), '1, 16'h3303, "R3");
      run_one(p_bc(4, 0), '1, 16'h3404, "R3");
   endtask

   task automatic t_swap();
      for (int g = 0; g <= 4; g++)
         run_one(p_sw(g), '1, 16'(16'h4100 + g), "R4");
   endtask

   task automatic t_reverse();
      for (int g = 1; g <= 5; g++)
         run_one(p_rv(g), '1, 16'(16'h5100 + g), "R5");
   endtask

   task automatic t_inactive();
      run_one(p_sw(0), 32'h5555_5555, 16'h6101, "R6");
      run_one(p_rv(5), 32'hF0C3_1A7E, 16'h6202, "R6");
      run_one(p_bc(5, 7), 32'hFFFF_FF7F, 16'h6303, "R6");
   endtask

   task automatic t_illegal();
      run_one({1'b0, 3'd4, 12'h000}, 32'h0F0F_0F0F, 16'h8101, "R8");
      run_one({1'b0, 3'd7, 12'h0E4}, 32'h0000_0001, 16'h8202, "R8");
      run_one(p_bc(0, 0), 32'h1234_5678, 16'h8303, "R8");
      run_one(p_bc(2, 4), '1, 16'h8404, "R8");
      run_one(p_bc(6, 0), '1, 16'h8505, "R8");
      run_one(p_sw(5), 32'hAAAA_0000, 16'h8606, "R8");
      run_one(p_rv(0), '1, 16'h8707, "R8");
      run_one(p_rv(6), '1, 16'h8808, "R8");
      run_one(p_quad(0, 1, 2, 3) | 16'h0100, '1, 16'h8909, "R8");
      run_one(p_sw(1) | 16'h0040, '1, 16'h8A0A, "R8");
   endtask

   task automatic t_stall();
      logic [BUSW-1:0] da, db, ea, eb;
      logic [15:0]     pa, pb;
      pa = {1'b0, 3'd5, 12'h000};
      pb = p_rv(5);
      da = mk_data(16'h9A01);
      db = mk_data(16'h9B02);
      ea = model(da, pa, '1);
      eb = model(db, pb, '1);
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1; in_data = da; in_pattern = pa; in_active = '1;
      @(negedge clk);
      in_data = db; in_pattern = pb;
      chk_bus(out_data, ea, "R8", "illegal pattern passes data under stall");
      chk_bit(out_err, 1'b1, "R8", "error raised under stall");
      chk_bit(in_ready, 1'b0, "R9", "ready low while full and stalled");
      @(negedge clk);
      chk_bit(out_err, 1'b0, "R8", "error one cycle under stall");
      for (int n = 0; n < 3; n++) begin
         chk_bit(out_valid, 1'b1, "R10", "valid held under stall");
         chk_bus(out_data, ea, "R10", "data held under stall");
         @(negedge clk);
      end
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk_bit(out_valid, 1'b1, "R9", "second request taken on release");
      chk_bus(out_data, eb, "R5", "second request result after stall");
      @(negedge clk);
      chk_bit(out_valid, 1'b0, "R10", "valid drops after final transfer");
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
      in_data = '0; in_pattern = '0; in_active = '0;
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_quad();
      t_default();
      t_bitmask();
      t_bcast();
      t_swap();
      t_reverse();
      t_inactive();
      t_illegal();
      t_stall();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule